// File: doc/BRIEF.md
# CAN Controller Interrupt and Error Capture Registers

This block is the interrupt and diagnostic register group of a CAN bus controller. The bit stream processor raises one-cycle event strobes for its interrupt sources: receive, transmit, error warning, data overrun, error passive, arbitration lost and bus error. Each source has its own enable bit. An interrupt flag is set only while its source is enabled, and the block drives one interrupt line that is high while any flag is set.

The block also keeps two diagnostic snapshots. The first is the bit position at which arbitration was lost. The second is the kind, direction and frame segment of the latest bus error. Each snapshot is taken on the first event after it was armed and then stays frozen until the processor reads it. A byte-wide, address-decoded port gives access to all four registers. Read data is combinational from the address. Read side effects and writes take place on the rising clock edge when the strobe is high.

Top module: `can_irq_regs`

## Requirements
- R1: After a synchronous reset, the enable, flag and both capture registers read as zero, `irq` is low, and both capture registers are armed.
- R2: The enable register is at address 4. Bit 7 enables bus error, bit 6 arbitration lost, bit 5 error passive, bit 3 data overrun, bit 2 error warning, bit 1 transmit and bit 0 receive. Bit 4 is unused: it reads 0 whatever was written.
- R3: The flag register is at address 3 and uses the same bit positions as the enable register. An event strobe on `src_evt[k]` sets flag k on the next edge only if enable bit k is 1. Flag bit 4 never sets.
- R4: A flag whose enable bit is 0 after a clock edge is cleared on that edge.
- R5: A read of address 3 returns the flags and clears every flag except the receive flag (bit 0). An enabled event in the same cycle sets its flag again.
- R6: `irq` is high exactly when at least one flag is set.
- R7: The arbitration capture register is at address 11. When it is armed and `src_evt[6]` pulses, bits 4:0 load `arb_bit` and the register disarms. Bits 7:5 always read 0. This capture does not depend on the enable bits.
- R8: While the arbitration capture register is disarmed, later arbitration events leave its value unchanged.
- R9: The error capture register is at address 12. When it is armed and `src_evt[7]` pulses, it loads three fields: the error kind in bits 7:6 (0 bit, 1 form, 2 stuff, 3 other), the direction in bit 5 (1 reception, 0 transmission) and the frame segment in bits 4:0.
- R10: While the error capture register is disarmed, later bus errors leave its value unchanged.
- R11: A read of a capture register returns the held value and re-arms it. If its event arrives in the same cycle as the read, the new data is loaded and the register stays disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; arms the read side effects |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| src_evt | input | 8 | One-cycle event strobes, one per flag bit position |
| arb_bit | input | 5 | Bit number at which arbitration was lost, valid with `src_evt[6]` |
| err_kind | input | 2 | Bus error kind, valid with `src_evt[7]` |
| err_rx | input | 1 | Bus error direction, 1 = reception, valid with `src_evt[7]` |
| err_seg | input | 5 | Frame segment of the bus error, valid with `src_evt[7]` |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a processor read and a new event at the same register: a flag read that coincides with an enabled strobe, and a capture read that coincides with a fresh arbitration or bus error. The second pair is an enable write and an event for the source being disabled. Directed sequences set up each collision on purpose. Random traffic over a fixed seed then produces many more of them. A bench model that applies the requirement rules in order judges every read value and the interrupt line: flags cleared first, then set, then masked by the new enables; captures loaded before re-arming.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int REG_W    = 8;
    localparam int BITNUM_W = 5;
    localparam int SEG_W    = 5;

    // Source bit positions, shared by enable and flag registers
    localparam int SRC_RX      = 0;
    localparam int SRC_TX      = 1;
    localparam int SRC_WARN    = 2;
    localparam int SRC_OVERRUN = 3;
    localparam int SRC_SPARE   = 4;
    localparam int SRC_PASSIVE = 5;
    localparam int SRC_ARB     = 6;
    localparam int SRC_BUSERR  = 7;

    localparam logic [REG_W-1:0] SRC_USABLE = ~(REG_W'(1) << SRC_SPARE);
    localparam logic [REG_W-1:0] SRC_STICKY = REG_W'(1) << SRC_RX;

    typedef enum logic [1:0] {
        ERR_BIT   = 2'd0,
        ERR_FORM  = 2'd1,
        ERR_STUFF = 2'd2,
        ERR_OTHER = 2'd3
    } err_kind_e;

    typedef struct packed {
        err_kind_e           kind;
        logic                rx_dir;
        logic [SEG_W-1:0]    seg;
    } err_snap_t;

    function automatic logic [REG_W-1:0] pad_bitnum(input logic [BITNUM_W-1:0] b);
        return REG_W'(b);
    endfunction

endpackage

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
#(
    parameter int               W      = REG_W,
    parameter logic [W-1:0]     USABLE = SRC_USABLE,
    parameter logic [W-1:0]     STICKY = SRC_STICKY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    input  logic         flag_rd,
    input  logic [W-1:0] src_evt,
    output logic [W-1:0] en_q,
    output logic [W-1:0] flags_q
);

    logic [W-1:0] en_next;
    logic [W-1:0] kept;
    logic [W-1:0] flags_next;

    always_comb begin
        en_next    = en_wr ? (en_wdata & USABLE) : en_q;
        kept       = flag_rd ? (flags_q & STICKY) : flags_q;
        flags_next = (kept | (src_evt & en_q & USABLE)) & en_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            flags_q <= '0;
        end else begin
            en_q    <= en_next;
            flags_q <= flags_next;
        end
    end

endmodule

// File: rtl/can_evt_capture.sv
module can_evt_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt,
    input  logic [W-1:0] evt_data,
    input  logic         rd,
    output logic [W-1:0] value_q,
    output logic         armed_q
);

    logic take;

    // A read in the same cycle counts as re-arming before the event
    assign take = evt && (armed_q || rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            armed_q <= 1'b1;
        end else if (take) begin
            value_q <= evt_data;
            armed_q <= 1'b0;
        end else if (rd) begin
            armed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/can_irq_regs.sv
module can_irq_regs
    import can_irq_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int A_FLAGS  = 3,
    parameter int A_ENABLE = 4,
    parameter int A_ARB    = 11,
    parameter int A_ERR    = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                rd_en,
    output logic [REG_W-1:0]    rd_data,
    input  logic [REG_W-1:0]    src_evt,
    input  logic [BITNUM_W-1:0] arb_bit,
    input  logic [1:0]          err_kind,
    input  logic                err_rx,
    input  logic [SEG_W-1:0]    err_seg,
    output logic                irq
);

    localparam int ERR_W = $bits(err_snap_t);

    logic                 sel_flags, sel_enable, sel_arb, sel_err;
    logic [REG_W-1:0]     ier_q, flags_q;
    logic [BITNUM_W-1:0]  alc_val;
    logic                 alc_armed;
    logic [ERR_W-1:0]     ecc_val;
    logic                 ecc_armed;
    err_snap_t            err_in;

    assign sel_flags  = (addr == ADDR_W'(A_FLAGS));
    assign sel_enable = (addr == ADDR_W'(A_ENABLE));
    assign sel_arb    = (addr == ADDR_W'(A_ARB));
    assign sel_err    = (addr == ADDR_W'(A_ERR));

    always_comb begin
        err_in.kind   = err_kind_e'(err_kind);
        err_in.rx_dir = err_rx;
        err_in.seg    = err_seg;
    end

    can_irq_flags #(
        .W      (REG_W),
        .USABLE (SRC_USABLE),
        .STICKY (SRC_STICKY)
    ) u_flags (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (wr_en && sel_enable),
        .en_wdata (wr_data),
        .flag_rd  (rd_en && sel_flags),
        .src_evt  (src_evt),
        .en_q     (ier_q),
        .flags_q  (flags_q)
    );

    can_evt_capture #(.W(BITNUM_W)) u_arb_cap (
        .clk      (clk),
        .rst      (rst),
        .evt      (src_evt[SRC_ARB]),
        .evt_data (arb_bit),
        .rd       (rd_en && sel_arb),
        .value_q  (alc_val),
        .armed_q  (alc_armed)
    );

    can_evt_capture #(.W(ERR_W)) u_err_cap (
        .clk      (clk),
        .rst      (rst),
        .evt      (src_evt[SRC_BUSERR]),
        .evt_data (err_in),
        .rd       (rd_en && sel_err),
        .value_q  (ecc_val),
        .armed_q  (ecc_armed)
    );

    always_comb begin
        rd_data = '0;
        if (sel_flags)       rd_data = flags_q;
        else if (sel_enable) rd_data = ier_q;
        else if (sel_arb)    rd_data = pad_bitnum(alc_val);
        else if (sel_err)    rd_data = REG_W'(ecc_val);
    end

    assign irq = |flags_q;

endmodule

// File: rtl/can_irq_regs_chk.sv
module can_irq_regs_chk
    import can_irq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                rd_en,
    input logic                sel_flags,
    input logic                sel_arb,
    input logic                sel_err,
    input logic [REG_W-1:0]    src_evt,
    input logic [BITNUM_W-1:0] arb_bit,
    input logic [REG_W-1:0]    ier_q,
    input logic [REG_W-1:0]    flags_q,
    input logic [BITNUM_W-1:0] alc_val,
    input logic                alc_armed,
    input logic [7:0]          ecc_val,
    input logic                ecc_armed,
    input logic                irq
);

    a_r3_spare_never_set: assert property (@(posedge clk) disable iff (rst)
        !flags_q[SRC_SPARE]);

    a_r3_quiet_stays_low: assert property (@(posedge clk) disable iff (rst)
        (!irq && ((src_evt & ier_q) == '0)) |=> !irq);

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel_flags && src_evt == '0) |=> (flags_q[7:1] == '0));

    a_r7_arb_capture: assert property (@(posedge clk) disable iff (rst)
        (alc_armed && src_evt[SRC_ARB]) |=> (alc_val == $past(arb_bit) && !alc_armed));

    a_r8_arb_hold: assert property (@(posedge clk) disable iff (rst)
        (!alc_armed && !(rd_en && sel_arb)) |=> ($stable(alc_val) && !alc_armed));

    a_r10_err_hold: assert property (@(posedge clk) disable iff (rst)
        (!ecc_armed && !(rd_en && sel_err)) |=> ($stable(ecc_val) && !ecc_armed));

    a_r11_rearm: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel_err && !src_evt[SRC_BUSERR]) |=> ecc_armed);

endmodule

bind can_irq_regs can_irq_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .sel_flags (sel_flags),
    .sel_arb   (sel_arb),
    .sel_err   (sel_err),
    .src_evt   (src_evt),
    .arb_bit   (arb_bit),
    .ier_q     (ier_q),
    .flags_q   (flags_q),
    .alc_val   (alc_val),
    .alc_armed (alc_armed),
    .ecc_val   (ecc_val),
    .ecc_armed (ecc_armed),
    .irq       (irq)
);

// File: tb/tb_can_irq_regs.sv
module tb_can_irq_regs;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] addr;
    logic       wr_en, rd_en, err_rx;
    logic [7:0] wr_data, rd_data, src_evt;
    logic [4:0] arb_bit, err_seg;
    logic [1:0] err_kind;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model state
    logic [7:0] m_ier, m_flg, m_ecc;
    logic [4:0] m_alc;
    bit         m_alc_arm, m_ecc_arm;

    always #4 clk = ~clk;

    can_irq_regs dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .src_evt(src_evt), .arb_bit(arb_bit),
        .err_kind(err_kind), .err_rx(err_rx), .err_seg(err_seg), .irq(irq)
    );

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'd3:    return m_flg;
            4'd4:    return m_ier;
            4'd11:   return {3'b000, m_alc};
            4'd12:   return m_ecc;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ier = 0; m_flg = 0; m_ecc = 0; m_alc = 0;
        m_alc_arm = 1; m_ecc_arm = 1;
    endtask

    task automatic model_step(input logic [7:0] ev, input logic [4:0] ab, input logic [7:0] ed,
                              input bit rd, input bit wr, input logic [3:0] a, input logic [7:0] wd);
        logic [7:0] ier_n, kept;
        ier_n = (wr && a == 4) ? (wd & 8'hEF) : m_ier;
        kept  = (rd && a == 3) ? (m_flg & 8'h01) : m_flg;
        m_flg = (kept | (ev & m_ier & 8'hEF)) & ier_n;
        m_ier = ier_n;
        if (ev[6] && (m_alc_arm || (rd && a == 11))) begin m_alc = ab; m_alc_arm = 0; end
        else if (rd && a == 11) m_alc_arm = 1;
        if (ev[7] && (m_ecc_arm || (rd && a == 12))) begin m_ecc = ed; m_ecc_arm = 0; end
        else if (rd && a == 12) m_ecc_arm = 1;
    endtask

    // One bus cycle: drive at negedge, check before posedge, advance model at edge
    task automatic cycle(input string tag, input logic [7:0] ev, input logic [4:0] ab,
                         input logic [1:0] ek, input bit erx, input logic [4:0] es,
                         input bit rd, input bit wr, input logic [3:0] a, input logic [7:0] wd);
        logic [7:0] exp;
        @(negedge clk);
        src_evt = ev; arb_bit = ab; err_kind = ek; err_rx = erx; err_seg = es;
        rd_en = rd; wr_en = wr; addr = a; wr_data = wd;
        #1;
        if (rd) begin
            exp = exp_read(a);
            check(rd_data === exp, tag, rd_data, exp);
        end
        check(irq === (m_flg != 0), "R6", {7'd0, irq}, {7'd0, (m_flg != 0)});
        @(posedge clk);
        model_step(ev, ab, {ek, erx, es}, rd, wr, a, wd);
    endtask

    task automatic rd_reg(input string tag, input logic [3:0] a);
        cycle(tag, 8'h00, 5'd0, 2'd0, 1'b0, 5'd0, 1'b1, 1'b0, a, 8'h00);
    endtask

    task automatic evt(input logic [7:0] ev, input logic [4:0] ab, input logic [1:0] ek,
                       input bit erx, input logic [4:0] es);
        cycle("R6", ev, ab, ek, erx, es, 1'b0, 1'b0, 4'd0, 8'h00);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        rst = 1; addr = 0; wr_en = 0; rd_en = 0; wr_data = 0; src_evt = 0;
        arb_bit = 0; err_kind = 0; err_rx = 0; err_seg = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        rd_reg("R1", 4'd3); rd_reg("R1", 4'd4); rd_reg("R1", 4'd11); rd_reg("R1", 4'd12);

        // R2 enable register, spare bit reads zero
        cycle("R2", 8'h00, 0, 0, 0, 0, 1'b0, 1'b1, 4'd4, 8'hFF);
        rd_reg("R2", 4'd4);

        // R3 only enabled sources set; spare bit never sets
        cycle("R3", 8'h00, 0, 0, 0, 0, 1'b0, 1'b1, 4'd4, 8'h05);
        evt(8'h1B, 5'd0, 0, 0, 0);
        rd_reg("R3", 4'd3);

        // R5 read clears all but receive; event in read cycle survives
        evt(8'h05, 5'd0, 0, 0, 0);
        cycle("R5", 8'h04, 0, 0, 0, 0, 1'b1, 1'b0, 4'd3, 8'h00);
        rd_reg("R5", 4'd3);

        // R4 disabling a source clears its flag, even with an event that cycle
        cycle("R4", 8'h01, 0, 0, 0, 0, 1'b0, 1'b1, 4'd4, 8'h04);
        rd_reg("R4", 4'd3);
        cycle("R4", 8'h00, 0, 0, 0, 0, 1'b0, 1'b1, 4'd4, 8'h00);
        rd_reg("R4", 4'd3);

        // R7/R8 arbitration capture: first wins, later ignored
        evt(8'h40, 5'd19, 0, 0, 0);
        evt(8'h40, 5'd7, 0, 0, 0);
        rd_reg("R7", 4'd11);
        // R11 event in the read cycle is captured for the next read
        cycle("R11", 8'h40, 5'd30, 0, 0, 0, 1'b1, 1'b0, 4'd11, 8'h00);
        evt(8'h40, 5'd2, 0, 0, 0);
        rd_reg("R8", 4'd11);

        // R9/R10 error capture fields: stuff error, reception, segment 13
        evt(8'h80, 5'd0, 2'd2, 1'b1, 5'd13);
        evt(8'h80, 5'd0, 2'd1, 1'b0, 5'd4);
        rd_reg("R9", 4'd12);
        rd_reg("R10", 4'd12);
        evt(8'h80, 5'd0, 2'd3, 1'b0, 5'd31);
        rd_reg("R11", 4'd12);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ev, wd;
            logic [3:0] a;
            bit rd, wr;
            int sel;
            ev  = 8'($urandom) & 8'($urandom) & 8'($urandom);
            sel = int'($urandom % 5);
            case (sel)
                0: a = 4'd3; 1: a = 4'd4; 2: a = 4'd11; 3: a = 4'd12;
                default: a = 4'($urandom);
            endcase
            rd = ($urandom % 3) == 0;
            wr = !rd && ($urandom % 6) == 0;
            if (wr && ($urandom % 2) == 0) a = 4'd4;
            wd = 8'($urandom);
            cycle((a == 4'd3) ? "R5" : (a == 4'd11) ? "R8" : (a == 4'd12) ? "R10" : "R2",
                  ev, 5'($urandom), 2'($urandom), 1'($urandom), 5'($urandom), rd, wr, a, wd);
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule